// File: doc/BRIEF.md
# Cluster Coherence Directory Controller

This block is the home directory of one cluster in a multi-cluster shared-memory machine. For each line of the cluster's local memory that is cached in at least one remote cluster, it keeps an entry with the line address, a Shared or Exclusive status and a vector of the remote clusters that hold the line. Requests from remote clusters arrive one per cycle, each tagged with the requester's cluster number. The controller looks up the line, updates the entry and produces outgoing messages. These are data replies to the requester, invalidates to the other sharers, and fetch (recall) requests to the cluster that owns a dirty copy.

Simple cases finish in the cycle the request is sampled. A write to a line with other sharers sends the invalidates one per cycle and waits until it has counted their acknowledgements. An access to a line held Exclusive by another cluster sends a fetch to the owner and waits for the write-back. While such a transaction is open, the controller refuses every new request with a negative acknowledgement on a separate channel, and the sender retries. A remote cluster that drops a line sends a release. When the last holder is removed, the entry is freed for reuse.

Top module: `cluster_dir`

## Requirements
- R1: A read (request kind 0) or write (kind 1) to a line with no entry allocates a free entry and is answered with a data reply (message kind 2) to the requester, carrying the line address, in the cycle after the request. A read allocates Shared and a write allocates Exclusive, each holding only the requester.
- R2: A read to a Shared line adds the requester to the sharer vector and is answered with a data reply in the cycle after the request.
- R3: A write to a Shared line that other clusters hold sends one invalidate (message kind 0) per cycle to each sharer other than the writer, in ascending cluster order. The first invalidate comes two cycles after the request.
- R4: After its invalidates, a write completes with a data reply to the writer in the cycle after the acknowledgement that brings the count up to the number of invalidates sent. The line is then Exclusive with only the writer.
- R5: A read or write to a line held Exclusive by another cluster sends a fetch (message kind 1) to the owner in the cycle after the request. The data reply follows in the cycle after the write-back is signalled. A read leaves the line Shared by the old owner and the reader. A write leaves it Exclusive to the writer.
- R6: A read or write by the cluster that already holds a line Exclusive is answered with a data reply in the next cycle, with no fetch.
- R7: A write by the only sharer of a Shared line is answered at once with a data reply and no invalidates, and the line becomes Exclusive to that cluster.
- R8: A release (request kind 2) removes the sender from the line's holders and sends no message. When no holder is left, the entry is freed and can be reused for any line.
- R9: Any request that arrives while an invalidate or fetch transaction is open gets a negative acknowledgement to its sender, with its address, in the next cycle, and leaves the directory unchanged.
- R10: A read or write to a line with no entry while every entry is in use gets a negative acknowledgement in the next cycle.
- R11: A valid entry always has at least one holder, and an Exclusive entry has exactly one.
- R12: Acknowledgements that arrive while no write is waiting on invalidates are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Incoming request valid |
| req_kind_i | input | 2 | 0 read, 1 write, 2 release |
| req_addr_i | input | ADDR_W | Line address of the request |
| req_src_i | input | CID_W | Requesting cluster number |
| inv_ack_valid_i | input | 1 | One invalidate acknowledgement received |
| wb_valid_i | input | 1 | Owner's write-back of a fetched line received |
| msg_valid_o | output | 1 | Outgoing message valid (one-cycle pulse) |
| msg_kind_o | output | 2 | 0 invalidate, 1 fetch, 2 data reply |
| msg_dst_o | output | CID_W | Destination cluster |
| msg_addr_o | output | ADDR_W | Line address of the message |
| nack_valid_o | output | 1 | Negative acknowledgement valid |
| nack_dst_o | output | CID_W | Cluster to retry |
| nack_addr_o | output | ADDR_W | Refused line address |

## Verification
Data replies for simple hits and allocations, fetches and negative acknowledgements all come from registers loaded at the edge that samples the request. The bench therefore drives each input on a falling edge and reads these results on the next falling edge. Invalidates start one cycle later and follow one per cycle, so the bench steps one falling edge per expected invalidate and checks for an idle cycle after the last one. Replies that wait on an acknowledgement or a write-back are checked on the falling edge after the edge that samples that input. The bench also checks that the reply is missing one edge earlier.

// File: rtl/cluster_dir_pkg.sv
package cluster_dir_pkg;
  typedef enum logic [1:0] {
    REQ_READ    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_RELEASE = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_INV   = 2'd0,
    MSG_FETCH = 2'd1,
    MSG_DATA  = 2'd2
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INV,
    ST_ACK,
    ST_FETCH
  } eng_state_e;
endpackage

// File: rtl/cdir_pick_low.sv
// Lowest set bit of a vector.
module cdir_pick_low #(
  parameter  int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cdir_match.sv
// Fully associative tag compare over the directory entries.
module cdir_match #(
  parameter  int N  = 8,
  parameter  int AW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid_i,
  input  logic [AW-1:0] tag_i [N],
  input  logic [AW-1:0] key_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  cdir_pick_low #(.W(N)) u_pick (
    .vec_i   (hit_vec),
    .found_o (hit_o),
    .idx_o   (idx_o)
  );
endmodule

// File: rtl/cluster_dir.sv
module cluster_dir
  import cluster_dir_pkg::*;
#(
  parameter  int N_CLUSTERS = 8,
  parameter  int N_ENTRIES  = 8,
  parameter  int ADDR_W     = 16,
  localparam int CID_W      = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CID_W-1:0]  req_src_i,
  input  logic              inv_ack_valid_i,
  input  logic              wb_valid_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_kind_o,
  output logic [CID_W-1:0]  msg_dst_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic              nack_valid_o,
  output logic [CID_W-1:0]  nack_dst_o,
  output logic [ADDR_W-1:0] nack_addr_o
);
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int CW = $clog2(N_CLUSTERS + 1);

  // directory storage
  logic [N_ENTRIES-1:0]  v_q;
  logic [N_ENTRIES-1:0]  excl_q;
  logic [ADDR_W-1:0]     addr_q [N_ENTRIES];
  logic [N_CLUSTERS-1:0] shr_q  [N_ENTRIES];

  // transaction engine
  eng_state_e            state_q;
  logic [IW-1:0]         cur_idx_q;
  logic [CID_W-1:0]      cur_src_q;
  logic [ADDR_W-1:0]     cur_addr_q;
  logic [1:0]            cur_kind_q;
  logic [CID_W-1:0]      owner_q;
  logic [N_CLUSTERS-1:0] pend_q;
  logic [CW-1:0]         sent_q;
  logic [CW-1:0]         acks_q;

  // output registers
  logic              msg_valid_q;
  logic [1:0]        msg_kind_q;
  logic [CID_W-1:0]  msg_dst_q;
  logic [ADDR_W-1:0] msg_addr_q;
  logic              nack_valid_q;
  logic [CID_W-1:0]  nack_dst_q;
  logic [ADDR_W-1:0] nack_addr_q;

  logic                  hit;
  logic [IW-1:0]         hit_idx;
  logic                  free_found;
  logic [IW-1:0]         free_idx;
  logic [N_CLUSTERS-1:0] hit_shr;
  logic                  hit_excl;
  logic                  own_found;
  logic [CID_W-1:0]      own_idx;
  logic                  inv_found;
  logic [CID_W-1:0]      inv_dst;
  logic [N_CLUSTERS-1:0] src_oh;
  logic [N_CLUSTERS-1:0] cur_src_oh;
  logic [N_CLUSTERS-1:0] owner_oh;
  logic [N_CLUSTERS-1:0] others;
  logic [N_CLUSTERS-1:0] pend_rest;
  logic [N_CLUSTERS-1:0] shr_left;
  logic [CW-1:0]         ack_sum;
  logic                  is_write;

  cdir_match #(.N(N_ENTRIES), .AW(ADDR_W)) u_match (
    .valid_i (v_q),
    .tag_i   (addr_q),
    .key_i   (req_addr_i),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  cdir_pick_low #(.W(N_ENTRIES)) u_free (
    .vec_i   (~v_q),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  cdir_pick_low #(.W(N_CLUSTERS)) u_owner (
    .vec_i   (hit_shr),
    .found_o (own_found),
    .idx_o   (own_idx)
  );

  cdir_pick_low #(.W(N_CLUSTERS)) u_inv (
    .vec_i   (pend_q),
    .found_o (inv_found),
    .idx_o   (inv_dst)
  );

  always_comb begin
    hit_shr    = shr_q[hit_idx];
    hit_excl   = excl_q[hit_idx];
    src_oh     = N_CLUSTERS'(1) << req_src_i;
    cur_src_oh = N_CLUSTERS'(1) << cur_src_q;
    owner_oh   = N_CLUSTERS'(1) << owner_q;
    others     = hit_shr & ~src_oh;
    shr_left   = hit_shr & ~src_oh;
    pend_rest  = pend_q & ~(N_CLUSTERS'(1) << inv_dst);
    ack_sum    = acks_q + CW'(inv_ack_valid_i);
    is_write   = (req_kind_i == REQ_WRITE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      v_q          <= '0;
      excl_q       <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        addr_q[i] <= '0;
        shr_q[i]  <= '0;
      end
      cur_idx_q    <= '0;
      cur_src_q    <= '0;
      cur_addr_q   <= '0;
      cur_kind_q   <= '0;
      owner_q      <= '0;
      pend_q       <= '0;
      sent_q       <= '0;
      acks_q       <= '0;
      msg_valid_q  <= 1'b0;
      msg_kind_q   <= '0;
      msg_dst_q    <= '0;
      msg_addr_q   <= '0;
      nack_valid_q <= 1'b0;
      nack_dst_q   <= '0;
      nack_addr_q  <= '0;
    end else begin
      msg_valid_q  <= 1'b0;
      nack_valid_q <= 1'b0;

      // engine busy: refuse everything
      if (req_valid_i && state_q != ST_IDLE) begin
        nack_valid_q <= 1'b1;
        nack_dst_q   <= req_src_i;
        nack_addr_q  <= req_addr_i;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            cur_src_q  <= req_src_i;
            cur_addr_q <= req_addr_i;
            cur_idx_q  <= hit_idx;
            cur_kind_q <= req_kind_i;
            case (req_kind_i)
              REQ_READ, REQ_WRITE: begin
                if (!hit) begin
                  if (free_found) begin
                    v_q[free_idx]    <= 1'b1;
                    excl_q[free_idx] <= is_write;
                    addr_q[free_idx] <= req_addr_i;
                    shr_q[free_idx]  <= src_oh;
                    msg_valid_q      <= 1'b1;
                    msg_kind_q       <= MSG_DATA;
                    msg_dst_q        <= req_src_i;
                    msg_addr_q       <= req_addr_i;
                  end else begin
                    nack_valid_q <= 1'b1;
                    nack_dst_q   <= req_src_i;
                    nack_addr_q  <= req_addr_i;
                  end
                end else if (hit_excl) begin
                  if (hit_shr[req_src_i]) begin
                    msg_valid_q <= 1'b1;
                    msg_kind_q  <= MSG_DATA;
                    msg_dst_q   <= req_src_i;
                    msg_addr_q  <= req_addr_i;
                  end else if (own_found) begin
                    // recall the dirty copy first
                    owner_q     <= own_idx;
                    msg_valid_q <= 1'b1;
                    msg_kind_q  <= MSG_FETCH;
                    msg_dst_q   <= own_idx;
                    msg_addr_q  <= req_addr_i;
                    state_q     <= ST_FETCH;
                  end
                end else if (!is_write) begin
                  shr_q[hit_idx] <= hit_shr | src_oh;
                  msg_valid_q    <= 1'b1;
                  msg_kind_q     <= MSG_DATA;
                  msg_dst_q      <= req_src_i;
                  msg_addr_q     <= req_addr_i;
                end else if (others == '0) begin
                  excl_q[hit_idx] <= 1'b1;
                  shr_q[hit_idx]  <= src_oh;
                  msg_valid_q     <= 1'b1;
                  msg_kind_q      <= MSG_DATA;
                  msg_dst_q       <= req_src_i;
                  msg_addr_q      <= req_addr_i;
                end else begin
                  pend_q  <= others;
                  sent_q  <= '0;
                  acks_q  <= '0;
                  state_q <= ST_INV;
                end
              end
              REQ_RELEASE: begin
                if (hit) begin
                  shr_q[hit_idx] <= shr_left;
                  if (shr_left == '0) begin
                    v_q[hit_idx]    <= 1'b0;
                    excl_q[hit_idx] <= 1'b0;
                  end
                end
              end
              default: ;
            endcase
          end
        end

        ST_INV: begin
          if (inv_found) begin
            msg_valid_q <= 1'b1;
            msg_kind_q  <= MSG_INV;
            msg_dst_q   <= inv_dst;
            msg_addr_q  <= cur_addr_q;
            sent_q      <= sent_q + CW'(1);
          end
          pend_q <= pend_rest;
          acks_q <= ack_sum;
          if (pend_rest == '0) state_q <= ST_ACK;
        end

        ST_ACK: begin
          if (ack_sum == sent_q) begin
            excl_q[cur_idx_q] <= 1'b1;
            shr_q[cur_idx_q]  <= cur_src_oh;
            msg_valid_q       <= 1'b1;
            msg_kind_q        <= MSG_DATA;
            msg_dst_q         <= cur_src_q;
            msg_addr_q        <= cur_addr_q;
            state_q           <= ST_IDLE;
          end else begin
            acks_q <= ack_sum;
          end
        end

        ST_FETCH: begin
          if (wb_valid_i) begin
            if (cur_kind_q == REQ_WRITE) begin
              excl_q[cur_idx_q] <= 1'b1;
              shr_q[cur_idx_q]  <= cur_src_oh;
            end else begin
              excl_q[cur_idx_q] <= 1'b0;
              shr_q[cur_idx_q]  <= cur_src_oh | owner_oh;
            end
            msg_valid_q <= 1'b1;
            msg_kind_q  <= MSG_DATA;
            msg_dst_q   <= cur_src_q;
            msg_addr_q  <= cur_addr_q;
            state_q     <= ST_IDLE;
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid_o  = msg_valid_q;
  assign msg_kind_o   = msg_kind_q;
  assign msg_dst_o    = msg_dst_q;
  assign msg_addr_o   = msg_addr_q;
  assign nack_valid_o = nack_valid_q;
  assign nack_dst_o   = nack_dst_q;
  assign nack_addr_o  = nack_addr_q;
endmodule

// File: rtl/cluster_dir_chk.sv
module cluster_dir_chk
  import cluster_dir_pkg::*;
#(
  parameter  int N_CLUSTERS = 8,
  parameter  int N_ENTRIES  = 8,
  parameter  int ADDR_W     = 16,
  localparam int CID_W      = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [CID_W-1:0]      req_src_i,
  input logic                  wb_valid_i,
  input logic                  msg_valid_o,
  input logic [1:0]            msg_kind_o,
  input logic                  nack_valid_o,
  input logic [CID_W-1:0]      nack_dst_o,
  input eng_state_e            state_q,
  input logic [N_CLUSTERS-1:0] pend_q,
  input logic [N_ENTRIES-1:0]  v_q,
  input logic [N_ENTRIES-1:0]  excl_q,
  input logic [N_CLUSTERS-1:0] shr_q [N_ENTRIES]
);
  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && state_q != ST_IDLE) |=> (nack_valid_o && nack_dst_o == $past(req_src_i))); // R9

  AST_NACK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_valid_o |-> $past(req_valid_i)); // R10

  AST_INV_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_kind_o == MSG_INV) |-> (state_q == ST_INV || state_q == ST_ACK)); // R3

  AST_ACK_PEND_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK) |-> (pend_q == '0)); // R4

  AST_FETCH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && wb_valid_i) |=> (msg_valid_o && msg_kind_o == MSG_DATA && state_q == ST_IDLE)); // R5

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    AST_EXCL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_q[g] && excl_q[g]) |-> ($countones(shr_q[g]) == 1)); // R11
    AST_ENTRY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q[g] |-> (shr_q[g] != '0)); // R11
  end
endmodule

bind cluster_dir cluster_dir_chk #(
  .N_CLUSTERS (N_CLUSTERS),
  .N_ENTRIES  (N_ENTRIES),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_src_i    (req_src_i),
  .wb_valid_i   (wb_valid_i),
  .msg_valid_o  (msg_valid_o),
  .msg_kind_o   (msg_kind_o),
  .nack_valid_o (nack_valid_o),
  .nack_dst_o   (nack_dst_o),
  .state_q      (state_q),
  .pend_q       (pend_q),
  .v_q          (v_q),
  .excl_q       (excl_q),
  .shr_q        (shr_q)
);

// File: tb/cluster_dir_test.sv
module cluster_dir_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, RL = 2'd2;
  localparam logic [1:0] K_INV = 2'd0, K_FETCH = 2'd1, K_DATA = 2'd2;
  localparam logic [15:0] LA = 16'h0100, LB = 16'h0200, LC = 16'h0300, LX = 16'h0900;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [2:0]  req_src_i = '0;
  logic        inv_ack_valid_i = 1'b0;
  logic        wb_valid_i = 1'b0;
  logic        msg_valid_o;
  logic [1:0]  msg_kind_o;
  logic [2:0]  msg_dst_o;
  logic [15:0] msg_addr_o;
  logic        nack_valid_o;
  logic [2:0]  nack_dst_o;
  logic [15:0] nack_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  cluster_dir uut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_kind_i      (req_kind_i),
    .req_addr_i      (req_addr_i),
    .req_src_i       (req_src_i),
    .inv_ack_valid_i (inv_ack_valid_i),
    .wb_valid_i      (wb_valid_i),
    .msg_valid_o     (msg_valid_o),
    .msg_kind_o      (msg_kind_o),
    .msg_dst_o       (msg_dst_o),
    .msg_addr_o      (msg_addr_o),
    .nack_valid_o    (nack_valid_o),
    .nack_dst_o      (nack_dst_o),
    .nack_addr_o     (nack_addr_o)
  );

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [2:0] s);
    req_valid_i = 1'b1;
    req_kind_i  = k;
    req_addr_i  = a;
    req_src_i   = s;
    step();
    req_valid_i = 1'b0;
  endtask

  task automatic pulse_ack();
    inv_ack_valid_i = 1'b1;
    step();
    inv_ack_valid_i = 1'b0;
  endtask

  task automatic pulse_wb();
    wb_valid_i = 1'b1;
    step();
    wb_valid_i = 1'b0;
  endtask

  task automatic chk_msg(input logic v, input logic [1:0] k, input logic [2:0] d,
                         input logic [15:0] a, input string tag);
    checks++;
    if (msg_valid_o !== v || (v && (msg_kind_o !== k || msg_dst_o !== d || msg_addr_o !== a))) begin
      errors++;
      $display("FAIL %s: got v=%0b kind=%0d dst=%0d addr=%h, expected v=%0b kind=%0d dst=%0d addr=%h",
               tag, msg_valid_o, msg_kind_o, msg_dst_o, msg_addr_o, v, k, d, a);
    end
  endtask

  task automatic chk_nack(input logic v, input logic [2:0] d, input logic [15:0] a, input string tag);
    checks++;
    if (nack_valid_o !== v || (v && (nack_dst_o !== d || nack_addr_o !== a))) begin
      errors++;
      $display("FAIL %s: got nack=%0b dst=%0d addr=%h, expected nack=%0b dst=%0d addr=%h",
               tag, nack_valid_o, nack_dst_o, nack_addr_o, v, d, a);
    end
  endtask

  task automatic t_reset();
    chk_msg(1'b0, '0, '0, '0, "reset: no message");
    chk_nack(1'b0, '0, '0, "reset: no nack");
  endtask

  task automatic t_read_share();
    issue(RD, LA, 3'd1); chk_msg(1'b1, K_DATA, 3'd1, LA, "R1 read allocates, reply");
    issue(RD, LA, 3'd3); chk_msg(1'b1, K_DATA, 3'd3, LA, "R2 second sharer reply");
    issue(RD, LA, 3'd5); chk_msg(1'b1, K_DATA, 3'd5, LA, "R2 third sharer reply");
  endtask

  task automatic t_write_inv();
    issue(WR, LA, 3'd3);
    chk_msg(1'b0, '0, '0, '0, "R3 nothing before first invalidate");
    req_valid_i = 1'b1; req_kind_i = RD; req_addr_i = LA; req_src_i = 3'd6;
    step();
    req_valid_i = 1'b0;
    chk_msg(1'b1, K_INV, 3'd1, LA, "R3 first invalidate to cluster 1");
    chk_nack(1'b1, 3'd6, LA, "R9 busy request refused");
    step(); chk_msg(1'b1, K_INV, 3'd5, LA, "R3 second invalidate to cluster 5");
    chk_nack(1'b0, '0, '0, "R9 nack only for the refused request");
    step(); chk_msg(1'b0, '0, '0, '0, "R3 no invalidate to writer");
    pulse_ack(); chk_msg(1'b0, '0, '0, '0, "R4 reply waits for all acks");
    pulse_ack(); chk_msg(1'b1, K_DATA, 3'd3, LA, "R4 reply after last ack");
  endtask

  task automatic t_fetch();
    issue(RD, LA, 3'd2); chk_msg(1'b1, K_FETCH, 3'd3, LA, "R5 fetch from exclusive owner");
    step(); chk_msg(1'b0, '0, '0, '0, "R5 no reply before write-back");
    pulse_wb(); chk_msg(1'b1, K_DATA, 3'd2, LA, "R5 reply after write-back");
    // line now shared by 2 and 3 only (R9: refused cluster 6 not added)
    issue(WR, LA, 3'd0); chk_msg(1'b0, '0, '0, '0, "R3 wait cycle");
    step(); chk_msg(1'b1, K_INV, 3'd2, LA, "R5 read left old owner sharing: inv 2");
    step(); chk_msg(1'b1, K_INV, 3'd3, LA, "R5 inv to old owner 3");
    pulse_ack(); chk_msg(1'b0, '0, '0, '0, "R9 refused cluster was never added");
    pulse_ack(); chk_msg(1'b1, K_DATA, 3'd0, LA, "R4 writer reply");
    issue(WR, LA, 3'd5); chk_msg(1'b1, K_FETCH, 3'd0, LA, "R4 writer is sole exclusive owner");
    pulse_wb(); chk_msg(1'b1, K_DATA, 3'd5, LA, "R5 write recall reply");
    issue(RD, LA, 3'd1); chk_msg(1'b1, K_FETCH, 3'd5, LA, "R5 write left line exclusive to writer");
    pulse_wb(); chk_msg(1'b1, K_DATA, 3'd1, LA, "R5 reply after recall");
  endtask

  task automatic t_owner_hit();
    issue(WR, LB, 3'd4); chk_msg(1'b1, K_DATA, 3'd4, LB, "R1 write allocates exclusive");
    issue(WR, LB, 3'd4); chk_msg(1'b1, K_DATA, 3'd4, LB, "R6 owner write hit");
    issue(RD, LB, 3'd4); chk_msg(1'b1, K_DATA, 3'd4, LB, "R6 owner read hit");
  endtask

  task automatic t_sole_sharer();
    issue(RD, LC, 3'd6); chk_msg(1'b1, K_DATA, 3'd6, LC, "R1 read allocate");
    issue(WR, LC, 3'd6); chk_msg(1'b1, K_DATA, 3'd6, LC, "R7 sole sharer upgrade, no invalidate");
    issue(RD, LC, 3'd7); chk_msg(1'b1, K_FETCH, 3'd6, LC, "R7 line became exclusive");
    pulse_wb(); chk_msg(1'b1, K_DATA, 3'd7, LC, "R5 reply");
  endtask

  task automatic t_release();
    issue(RL, LC, 3'd6); chk_msg(1'b0, '0, '0, '0, "R8 release sends nothing");
    issue(RL, LC, 3'd7); chk_msg(1'b0, '0, '0, '0, "R8 last release sends nothing");
    issue(WR, LC, 3'd1); chk_msg(1'b1, K_DATA, 3'd1, LC, "R8 freed line: write answered at once");
  endtask

  task automatic t_table_full();
    for (int i = 0; i < 5; i++) begin
      issue(RD, 16'h0400 + 16'(i) * 16'h0100, 3'd0);
      chk_msg(1'b1, K_DATA, 3'd0, 16'h0400 + 16'(i) * 16'h0100, "R1 fill directory");
    end
    issue(RD, LX, 3'd2);
    chk_nack(1'b1, 3'd2, LX, "R10 full directory refuses new line");
    chk_msg(1'b0, '0, '0, '0, "R10 no reply when full");
    issue(RL, 16'h0400, 3'd0); chk_msg(1'b0, '0, '0, '0, "R8 release frees entry");
    issue(RD, LX, 3'd2); chk_msg(1'b1, K_DATA, 3'd2, LX, "R8 freed entry reused");
  endtask

  task automatic t_stray_ack();
    issue(RD, 16'h0500, 3'd2); chk_msg(1'b1, K_DATA, 3'd2, 16'h0500, "R2 add sharer");
    pulse_ack(); chk_msg(1'b0, '0, '0, '0, "R12 idle ack ignored");
    chk_nack(1'b0, '0, '0, "R12 idle ack no nack");
    issue(WR, 16'h0500, 3'd2); chk_msg(1'b0, '0, '0, '0, "R3 wait cycle");
    step(); chk_msg(1'b1, K_INV, 3'd0, 16'h0500, "R3 invalidate other sharer");
    step(); chk_msg(1'b0, '0, '0, '0, "R12 stray ack not counted");
    pulse_ack(); chk_msg(1'b1, K_DATA, 3'd2, 16'h0500, "R4 reply after ack");
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_read_share();
    t_write_inv();
    t_fetch();
    t_owner_hit();
    t_sole_sharer();
    t_release();
    t_table_full();
    t_stray_ack();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule